// File: doc/BRIEF.md
# Strap-Sampled Control Register Bank

This block is the configuration front end of a mixed-signal interface device. When the hardware reset is released it captures two board-level strap pins. One strap chooses between register-driven control and pin-driven control. The other strap supplies the clock-role selection that applies in pin-driven control. A simple parallel write port and read port give access to a small register file. The file holds identification constants, a revision field, a power-down register and a port-configuration register.

A write to address 0x00 is not stored. It returns every writable register to its default value, and those defaults leave every function powered down. The block gives downstream logic its effective settings: one power-down line per function, the master/slave role, and the chosen control mode. In pin-driven control the power-down lines are held in the powered-up state, and the role comes from the strap.

Top module: `cb_ctrl_top`

## Requirements
- R1: After a hardware reset, the power-down register (address 0x03) reads 0x3F and the port register (address 0x04) reads 0x00. With the data strap high, `pwr_dn_o` is all ones, `master_o` is 0 and `hw_mode_o` is 0.
- R2: A read of address 0x00 returns 0x05, and a read of address 0x01 returns 0x88.
- R3: A read of address 0x02 returns the 4-bit revision (default 1) in bits 3:0, and bits 7:4 read as zero.
- R4: Writes to addresses 0x01 and 0x02 change no readable value.
- R5: A write to address 0x00 discards its data and returns every writable register to its default. A read in the next cycle sees those defaults, and in register-driven mode `pwr_dn_o` returns to all ones.
- R6: A soft reset does not re-sample the straps, so `hw_mode_o` and a strap-sourced `master_o` keep their values.
- R7: The straps are captured only on the first rising clock edge at which `rst_n` is sampled high, and they hold until the next hardware reset. `strap_sdin_i` low selects pin-driven mode (`hw_mode_o` = 1).
- R8: In pin-driven mode `pwr_dn_o` is all zeros (powered up), whatever the register contents.
- R9: `master_o` = 1 means master and 0 means slave. In register-driven mode it follows bit 0 of address 0x04. In pin-driven mode it follows the captured `strap_sclk_i`.
- R10: In pin-driven mode, writes to 0x03 and 0x04 are stored and read back, but they leave `pwr_dn_o` and `master_o` unchanged.
- R11: Reads of any address above 0x04 return 0x00, and writes to those addresses have no effect.
- R12: In register-driven mode, a write to 0x03 drives `pwr_dn_o` from data bits 5:0 in the next cycle. Bits 7:6 of that register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap_sdin_i | input | 1 | Control-mode strap (0 selects pin-driven mode) |
| strap_sclk_i | input | 1 | Role strap used in pin-driven mode (1 selects master) |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 7 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 7 | Read address |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| pwr_dn_o | output | 6 | Effective power-down per function (1 = powered down) |
| master_o | output | 1 | Effective role (1 = master) |
| hw_mode_o | output | 1 | Captured control mode (1 = pin-driven) |

## Verification
A corrupted stored register shows on `rd_data_o` in the same cycle its address is presented. In register-driven mode it also shows on `pwr_dn_o` or `master_o` one cycle after the write that caused it. A strap latch that captures on the wrong edge, or that re-samples later, shows on `hw_mode_o` in the cycle after the pins move. A soft reset that misses a register leaves a non-default read-back in the cycle after the write to address 0x00.

// File: rtl/cb_ctrl_pkg.sv
// Shared constants and types for the control register bank.
// Assumes a 7-bit register address space and byte-wide registers.
package cb_ctrl_pkg;
    localparam int ADDR_ID_LO  = 0;   // soft reset on write, ID on read
    localparam int ADDR_ID_HI  = 1;
    localparam int ADDR_REV    = 2;
    localparam int ADDR_PWR    = 3;
    localparam int ADDR_PORT   = 4;
    localparam int MS_BIT      = 0;   // role bit inside the port register

    typedef struct packed {
        logic hw_mode;   // 1 = pin-driven control
        logic sclk;      // role strap level
    } strap_t;
endpackage

// File: rtl/cb_strap_latch.sv
// Captures the strap pins on the first clock edge after hardware reset
// is released and holds them until the next hardware reset.
// Assumes the straps are static around reset release (no synchronizer).
module cb_strap_latch
    import cb_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sdin_i,
    input  logic   sclk_i,
    output strap_t strap_o
);
    logic   armed_q;
    strap_t strap_q;

    // One-shot capture on the release edge, frozen afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q         <= 1'b0;
            strap_q.hw_mode <= 1'b0;
            strap_q.sclk    <= 1'b0;
        end else if (!armed_q) begin
            armed_q         <= 1'b1;
            strap_q.hw_mode <= ~sdin_i;
            strap_q.sclk    <= sclk_i;
        end
    end

    assign strap_o = strap_q;
endmodule

// File: rtl/cb_reg_cell.sv
// One writable register: loads on an address match and returns to its
// default on hardware reset or soft reset.
// Assumes the caller decodes the soft-reset strobe.
module cb_reg_cell #(
    parameter int          AW   = 7,
    parameter int          W    = 8,
    parameter int          ADDR = 3,
    parameter logic [W-1:0] DEF = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    output logic [W-1:0]  q_o
);
    logic hit;

    // Address match for this cell
    assign hit = wr_en_i && (wr_addr_i == AW'(ADDR));

    // Storage with default restore
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) q_o <= DEF;
        else if (hit)             q_o <= wr_data_i;
    end
endmodule

// File: rtl/cb_regfile.sv
// Writable register file: decodes the soft-reset strobe and holds the
// power-down and port-configuration registers.
// Assumes only one write per cycle.
module cb_regfile
    import cb_ctrl_pkg::*;
#(
    parameter int AW   = 7,
    parameter int DW   = 8,
    parameter int PD_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [PD_W-1:0] pwr_q_o,
    output logic [DW-1:0]   port_q_o
);
    logic soft_rst;

    // Write to the ID address acts as a soft reset
    assign soft_rst = wr_en_i && (wr_addr_i == AW'(ADDR_ID_LO));

    cb_reg_cell #(.AW(AW), .W(PD_W), .ADDR(ADDR_PWR), .DEF({PD_W{1'b1}})) u_pwr (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i[PD_W-1:0]), .q_o(pwr_q_o)
    );

    cb_reg_cell #(.AW(AW), .W(DW), .ADDR(ADDR_PORT), .DEF('0)) u_port (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .q_o(port_q_o)
    );
endmodule

// File: rtl/cb_read_mux.sv
// Combinational read path: identification constants, revision, stored
// registers, zero for every other address.
// Assumes PD_W and the revision width do not exceed DW.
module cb_read_mux
    import cb_ctrl_pkg::*;
#(
    parameter int          AW    = 7,
    parameter int          DW    = 8,
    parameter int          PD_W  = 6,
    parameter logic [DW-1:0] ID_LO = 8'h05,
    parameter logic [DW-1:0] ID_HI = 8'h88,
    parameter logic [3:0]  REV   = 4'h1
) (
    input  logic [AW-1:0]   rd_addr_i,
    input  logic [PD_W-1:0] pwr_q_i,
    input  logic [DW-1:0]   port_q_i,
    output logic [DW-1:0]   rd_data_o
);
    // Address decode with zero fill
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            AW'(ADDR_ID_LO): rd_data_o = ID_LO;
            AW'(ADDR_ID_HI): rd_data_o = ID_HI;
            AW'(ADDR_REV):   rd_data_o[3:0] = REV;
            AW'(ADDR_PWR):   rd_data_o[PD_W-1:0] = pwr_q_i;
            AW'(ADDR_PORT):  rd_data_o = port_q_i;
            default:         rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/cb_out_sel.sv
// Output selection: in pin-driven mode the power-down lines are held
// powered up and the role comes from the strap; otherwise registers rule.
// Assumes straps are already captured.
module cb_out_sel
    import cb_ctrl_pkg::*;
#(
    parameter int DW   = 8,
    parameter int PD_W = 6
) (
    input  strap_t          strap_i,
    input  logic [PD_W-1:0] pwr_q_i,
    input  logic [DW-1:0]   port_q_i,
    output logic [PD_W-1:0] pwr_dn_o,
    output logic            master_o
);
    // Per-function power-down gating
    for (genvar i = 0; i < PD_W; i++) begin : g_pd
        assign pwr_dn_o[i] = pwr_q_i[i] & ~strap_i.hw_mode;
    end

    // Role source selection
    assign master_o = strap_i.hw_mode ? strap_i.sclk : port_q_i[MS_BIT];
endmodule

// File: rtl/cb_ctrl_top.sv
// Top of the control register bank: strap capture, register file,
// read path and output selection.
// Assumes rst_n is synchronous to clk and held for at least one edge.
module cb_ctrl_top
    import cb_ctrl_pkg::*;
#(
    parameter int         AW   = 7,
    parameter int         DW   = 8,
    parameter int         PD_W = 6,
    parameter logic [3:0] REV  = 4'h1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_sdin_i,
    input  logic            strap_sclk_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    input  logic [AW-1:0]   rd_addr_i,
    output logic [DW-1:0]   rd_data_o,
    output logic [PD_W-1:0] pwr_dn_o,
    output logic            master_o,
    output logic            hw_mode_o
);
    strap_t            strap;
    logic [PD_W-1:0]   pwr_q;
    logic [DW-1:0]     port_q;

    cb_strap_latch u_strap (
        .clk(clk), .rst_n(rst_n), .sdin_i(strap_sdin_i),
        .sclk_i(strap_sclk_i), .strap_o(strap)
    );

    cb_regfile #(.AW(AW), .DW(DW), .PD_W(PD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .pwr_q_o(pwr_q), .port_q_o(port_q)
    );

    cb_read_mux #(.AW(AW), .DW(DW), .PD_W(PD_W), .REV(REV)) u_rd (
        .rd_addr_i(rd_addr_i), .pwr_q_i(pwr_q), .port_q_i(port_q),
        .rd_data_o(rd_data_o)
    );

    cb_out_sel #(.DW(DW), .PD_W(PD_W)) u_out (
        .strap_i(strap), .pwr_q_i(pwr_q), .port_q_i(port_q),
        .pwr_dn_o(pwr_dn_o), .master_o(master_o)
    );

    // Expose the captured mode
    assign hw_mode_o = strap.hw_mode;
endmodule

// File: rtl/cb_ctrl_chk.sv
// Port-level property checker for cb_ctrl_top, bound to every instance.
module cb_ctrl_chk #(
    parameter int         AW   = 7,
    parameter int         DW   = 8,
    parameter int         PD_W = 6,
    parameter logic [3:0] REV  = 4'h1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en_i,
    input logic [AW-1:0]   wr_addr_i,
    input logic [AW-1:0]   rd_addr_i,
    input logic [DW-1:0]   rd_data_o,
    input logic [PD_W-1:0] pwr_dn_o,
    input logic            master_o,
    input logic            hw_mode_o
);
    p_id_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_i == AW'(0) |-> rd_data_o == 8'h05);
    p_id_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_i == AW'(1) |-> rd_data_o == 8'h88);
    p_rev_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_i == AW'(2) |-> rd_data_o == DW'(REV));
    p_soft_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i && wr_addr_i == AW'(0)) && !hw_mode_o) |-> pwr_dn_o == {PD_W{1'b1}});
    p_strap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> $stable(hw_mode_o));
    p_hw_powered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode_o |-> pwr_dn_o == '0);
    p_hw_role_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode_o && $past(hw_mode_o)) |-> $stable(master_o));
    p_unimpl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_i > AW'(4) |-> rd_data_o == '0);
endmodule

bind cb_ctrl_top cb_ctrl_chk #(.AW(AW), .DW(DW), .PD_W(PD_W), .REV(REV)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .pwr_dn_o(pwr_dn_o),
    .master_o(master_o), .hw_mode_o(hw_mode_o)
);

// File: tb/tb_cb_ctrl_top.sv
module tb_cb_ctrl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdin = 1'b1, sclk = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [5:0] pwr_dn;
    logic       master, hw_mode;
    int         checks = 0, errors = 0;

    always #4 clk = ~clk;

    cb_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .strap_sdin_i(sdin), .strap_sclk_i(sclk),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pwr_dn_o(pwr_dn),
        .master_o(master), .hw_mode_o(hw_mode)
    );

    typedef struct packed {
        logic       wr;
        logic [6:0] addr;
        logic [7:0] data;   // write data or expected read data
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 7'h00, 8'h05, 4'd2},   // R2
        '{1'b0, 7'h01, 8'h88, 4'd2},   // R2
        '{1'b0, 7'h02, 8'h01, 4'd3},   // R3
        '{1'b0, 7'h03, 8'h3F, 4'd1},   // R1
        '{1'b0, 7'h04, 8'h00, 4'd1},   // R1
        '{1'b1, 7'h01, 8'hAA, 4'd4},   // R4
        '{1'b0, 7'h01, 8'h88, 4'd4},
        '{1'b1, 7'h02, 8'hFF, 4'd4},
        '{1'b0, 7'h02, 8'h01, 4'd4},
        '{1'b1, 7'h03, 8'hC5, 4'd12},  // R12
        '{1'b0, 7'h03, 8'h05, 4'd12},
        '{1'b1, 7'h04, 8'h81, 4'd9},   // R9
        '{1'b0, 7'h04, 8'h81, 4'd9},
        '{1'b0, 7'h07, 8'h00, 4'd11},  // R11
        '{1'b1, 7'h07, 8'h55, 4'd11},
        '{1'b0, 7'h07, 8'h00, 4'd11},
        '{1'b0, 7'h7F, 8'h00, 4'd11}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [6:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic hw_reset(input logic s_d, input logic s_c);
        @(negedge clk);
        rst_n = 1'b0; sdin = s_d; sclk = s_c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        hw_reset(1'b1, 1'b0);
        // R1 reset state at the ports
        check("R1 pwr_dn", {2'b0, pwr_dn}, 8'h3F);
        check("R1 master", {7'b0, master}, 8'h00);
        check("R1 hw_mode", {7'b0, hw_mode}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else rd($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
        end
        // R12 and R9: register values reach the outputs in register-driven mode
        #1;
        check("R12 pwr_dn follows reg", {2'b0, pwr_dn}, 8'h05);
        check("R9 master from reg bit0", {7'b0, master}, 8'h01);

        // R5 soft reset restores defaults, data discarded
        wr(7'h00, 8'hFF);
        rd("R5 pwr reg", 7'h03, 8'h3F);
        rd("R5 port reg", 7'h04, 8'h00);
        check("R5 pwr_dn", {2'b0, pwr_dn}, 8'h3F);
        check("R5 master", {7'b0, master}, 8'h00);

        // R6 soft reset does not re-sample straps
        sdin = 1'b0; sclk = 1'b1;
        wr(7'h00, 8'h00);
        #1;
        check("R6 hw_mode kept", {7'b0, hw_mode}, 8'h00);

        // R7/R8/R9 pin-driven mode after a new hardware reset
        hw_reset(1'b0, 1'b1);
        check("R7 hw_mode", {7'b0, hw_mode}, 8'h01);
        check("R8 powered up", {2'b0, pwr_dn}, 8'h00);
        check("R9 master from strap", {7'b0, master}, 8'h01);
        sdin = 1'b1; sclk = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R7 frozen hw_mode", {7'b0, hw_mode}, 8'h01);
        check("R7 frozen master", {7'b0, master}, 8'h01);

        // R10 writes stored but outputs unaffected
        wr(7'h03, 8'h3F);
        wr(7'h04, 8'h00);
        rd("R10 pwr readback", 7'h03, 8'h3F);
        rd("R10 port readback", 7'h04, 8'h00);
        check("R10 pwr_dn", {2'b0, pwr_dn}, 8'h00);
        check("R10 master", {7'b0, master}, 8'h01);

        // R6 in pin-driven mode
        wr(7'h00, 8'h12);
        #1;
        check("R6 hw_mode after soft reset", {7'b0, hw_mode}, 8'h01);
        check("R6 master after soft reset", {7'b0, master}, 8'h01);

        // R7 capture edge only: pin moves right after release
        @(negedge clk);
        rst_n = 1'b0; sdin = 1'b1; sclk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sdin = 1'b0; sclk = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R7 capture edge hw_mode", {7'b0, hw_mode}, 8'h00);
        check("R7 capture edge master", {7'b0, master}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule